// File: doc/BRIEF.md
# Write-Once Special Mode Register

This block is a 16-bit control register inside a supervisory controller. A serial-frame front end hands it one parallel 16-bit command word per frame. The block answers each frame addressed to it with one of two interrupt feedback words. It holds three control flags: a software-development flag, an error-pin emulation flag and a limp-home flag.

After a power-on reset the register takes exactly one write, and only while the device is in start-up mode and before the Mode register is first written. A read-only command bit lets software read without spending that single write. A high-voltage level on the test pin at power-on sets the software-development flag without any write. The Mode register path can clear that flag at any time. The flags drive three things: a suppress output for the supervision logic, the source of the enable/error pin, and the value that the limp-home configuration bit takes on entry to fail-safe.

Top module: `smr_once_reg`

## Requirements
- R1: A frame selects this register only when command bits [15:14] equal 01. Any other address leaves the stored word unchanged and produces no read return.
- R2: After a power-on reset, only the first accepted write changes the stored flags. Every later write is ignored until the next reset.
- R3: A write is accepted only while `in_startup` is 1 and before the first `mode_reg_wr` pulse. A `mode_reg_wr` pulse closes the lock even if no write has happened. A `mode_reg_wr` pulse in the same cycle as a write frame rejects that write.
- R4: When command bit 12 (read-only) is 1, the frame returns read data, leaves the stored word unchanged and does not consume the write.
- R5: Every selected frame, write or read-only, raises `rd_valid` for one cycle on the cycle after the frame. `rd_data` then holds `irq_en_fb` when command bit 13 is 0 and `irq_fb` when it is 1.
- R6: If `test_hv` is 1 on the first clock after reset is released, the software-development flag (`smr_word` bit 9) is set. A `test_hv` level seen later has no effect.
- R7: A `sdm_clear` pulse clears the software-development flag on the next cycle, even when the register is locked and even when a write in the same cycle sets it.
- R8: `en_pin` is registered one cycle behind its inputs. When the emulation flag (`smr_word` bit 8) is 1, it is 1 exactly when `busfail_diag` is all zeros. When the flag is 0, it follows `en_normal`.
- R9: On a `failsafe_entry` pulse, `cfg_limp` takes the limp-home flag (`smr_word` bit 7) on the next cycle. Otherwise `cfg_limp` holds its value.
- R10: `suppress` equals the software-development flag.
- R11: Written values are stored only in bits 9, 8 and 7. All other `smr_word` bits read 0.
- R12: A reset clears `smr_word`, `rd_valid`, `rd_data`, `en_pin`, `cfg_limp` and `suppress`, and it reopens the write lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| frame_valid | input | 1 | One-cycle strobe: a command word is present |
| frame_word | input | 16 | Command word from the serial front end |
| in_startup | input | 1 | Device is in start-up mode |
| mode_reg_wr | input | 1 | Pulse: the Mode register is being written |
| sdm_clear | input | 1 | Pulse from the Mode register path: clear the software-development flag |
| test_hv | input | 1 | Test pin is at or above its high-voltage threshold |
| irq_en_fb | input | DATA_W | Interrupt-enable feedback word |
| irq_fb | input | DATA_W | Interrupt feedback word |
| busfail_diag | input | DIAG_W | Bus-failure diagnosis field |
| en_normal | input | 1 | Normal enable-function value for the pin |
| failsafe_entry | input | 1 | Pulse: entering fail-safe mode |
| rd_valid | output | 1 | Read data returned for the previous frame |
| rd_data | output | DATA_W | Read return word |
| smr_word | output | 16 | Stored register contents |
| suppress | output | 1 | Blocks supervision resets and fail-safe transitions |
| en_pin | output | 1 | Enable/error pin value |
| cfg_limp | output | 1 | Limp-home configuration bit |

## Verification
A frame presented on one clock edge changes `smr_word`, `suppress`, `rd_valid` and `rd_data` on that same edge. `en_pin` depends on the stored emulation flag, so it lags one edge further: two edges after the frame. `cfg_limp` changes one edge after `failsafe_entry`. The test-pin sample is taken on the first edge after reset is released. The bench drives every input on the falling edge and reads results on the following falling edges, so each check lands after exactly the number of register stages listed above.

// File: rtl/smr_pkg.sv
`timescale 1ns/1ps
package smr_pkg;
  localparam int CMD_W    = 16;
  localparam int ADDR_HI  = 15;
  localparam int ADDR_LO  = 14;
  localparam int POS_PICK = 13;
  localparam int POS_RO   = 12;
  localparam int POS_DEV  = 9;
  localparam int POS_EMU  = 8;
  localparam int POS_LIMP = 7;
  localparam logic [CMD_W-1:0] KEEP_MASK =
    (CMD_W'(1) << POS_DEV) | (CMD_W'(1) << POS_EMU) | (CMD_W'(1) << POS_LIMP);

  typedef struct packed {
    logic hit;
    logic pick;
    logic wr_req;
  } cmd_dec_t;
endpackage

// File: rtl/smr_decode.sv
`timescale 1ns/1ps
module smr_decode
  import smr_pkg::*;
#(
  parameter logic [1:0] SEL_ADDR = 2'b01
) (
  input  logic             frame_valid,
  input  logic [CMD_W-1:0] frame_word,
  output cmd_dec_t         dec
);
  logic addr_match;

  always_comb begin
    addr_match = (frame_word[ADDR_HI:ADDR_LO] == SEL_ADDR);
    dec.hit    = frame_valid && addr_match;
    dec.pick   = frame_word[POS_PICK];
    dec.wr_req = frame_valid && addr_match && !frame_word[POS_RO];
  end
endmodule

// File: rtl/smr_store.sv
`timescale 1ns/1ps
module smr_store
  import smr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_req,
  input  logic [CMD_W-1:0] frame_word,
  input  logic             in_startup,
  input  logic             mode_reg_wr,
  input  logic             sdm_clear,
  input  logic             test_hv,
  output logic [CMD_W-1:0] smr_q
);
  logic             open_q;
  logic             first_q;
  logic             wr_ok;
  logic [CMD_W-1:0] smr_nxt;

  always_comb begin
    wr_ok   = wr_req && in_startup && open_q && !mode_reg_wr;
    smr_nxt = wr_ok ? (frame_word & KEEP_MASK) : smr_q;
    if (first_q && test_hv) smr_nxt[POS_DEV] = 1'b1;
    if (sdm_clear)          smr_nxt[POS_DEV] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smr_q   <= '0;
      open_q  <= 1'b1;
      first_q <= 1'b1;
    end else begin
      smr_q   <= smr_nxt;
      first_q <= 1'b0;
      if (wr_ok || mode_reg_wr) open_q <= 1'b0;
    end
  end

  p_once_r2: assert property (@(posedge clk) disable iff (rst)
    (!open_q) |=> $stable(smr_q[POS_EMU:POS_LIMP]))
    else $error("R2: stored flags changed after lock closed");

  p_mode_close_r3: assert property (@(posedge clk) disable iff (rst)
    mode_reg_wr |=> !open_q)
    else $error("R3: lock open after mode register write");

  p_test_sample_r6: assert property (@(posedge clk) disable iff (rst)
    (first_q && test_hv && !sdm_clear) |=> smr_q[POS_DEV])
    else $error("R6: test pin sample did not set flag");

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    sdm_clear |=> !smr_q[POS_DEV])
    else $error("R7: clear did not take effect");

  p_rsv_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (smr_q & ~KEEP_MASK) == '0)
    else $error("R11: reserved bit stored");
endmodule

// File: rtl/smr_readback.sv
`timescale 1ns/1ps
module smr_readback #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              pick,
  input  logic [DATA_W-1:0] irq_en_fb,
  input  logic [DATA_W-1:0] irq_fb,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= hit;
      if (hit) rd_data <= pick ? irq_fb : irq_en_fb;
    end
  end

  p_rd_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    hit |=> rd_valid)
    else $error("R5: no read return after selected frame");

  p_rd_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !hit |=> !rd_valid)
    else $error("R1: read return without selected frame");

  p_rd_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(rd_data))
    else $error("R5: read data moved without a frame");
endmodule

// File: rtl/smr_pin.sv
`timescale 1ns/1ps
module smr_pin #(
  parameter int DIAG_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              emu,
  input  logic              limp,
  input  logic [DIAG_W-1:0] busfail_diag,
  input  logic              en_normal,
  input  logic              failsafe_entry,
  output logic              en_pin,
  output logic              cfg_limp
);
  logic diag_clean;

  always_comb diag_clean = (busfail_diag == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_pin   <= 1'b0;
      cfg_limp <= 1'b0;
    end else begin
      en_pin <= emu ? diag_clean : en_normal;
      if (failsafe_entry) cfg_limp <= limp;
    end
  end

  p_emu_pin_r8: assert property (@(posedge clk) disable iff (rst)
    emu |=> (en_pin == ($past(busfail_diag) == '0)))
    else $error("R8: emulated pin value wrong");

  p_normal_pin_r8: assert property (@(posedge clk) disable iff (rst)
    !emu |=> (en_pin == $past(en_normal)))
    else $error("R8: pin does not follow enable");

  p_limp_entry_r9: assert property (@(posedge clk) disable iff (rst)
    failsafe_entry |=> (cfg_limp == $past(limp)))
    else $error("R9: limp bit not applied on entry");

  p_limp_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !failsafe_entry |=> $stable(cfg_limp))
    else $error("R9: limp bit moved without entry");
endmodule

// File: rtl/smr_once_reg.sv
`timescale 1ns/1ps
module smr_once_reg
  import smr_pkg::*;
#(
  parameter int         DATA_W   = 16,
  parameter int         DIAG_W   = 4,
  parameter logic [1:0] SEL_ADDR = 2'b01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_valid,
  input  logic [15:0]       frame_word,
  input  logic              in_startup,
  input  logic              mode_reg_wr,
  input  logic              sdm_clear,
  input  logic              test_hv,
  input  logic [DATA_W-1:0] irq_en_fb,
  input  logic [DATA_W-1:0] irq_fb,
  input  logic [DIAG_W-1:0] busfail_diag,
  input  logic              en_normal,
  input  logic              failsafe_entry,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [15:0]       smr_word,
  output logic              suppress,
  output logic              en_pin,
  output logic              cfg_limp
);
  cmd_dec_t dec;

  smr_decode #(.SEL_ADDR(SEL_ADDR)) u_dec (
    .frame_valid (frame_valid),
    .frame_word  (frame_word),
    .dec         (dec)
  );

  smr_store u_store (
    .clk         (clk),
    .rst         (rst),
    .wr_req      (dec.wr_req),
    .frame_word  (frame_word),
    .in_startup  (in_startup),
    .mode_reg_wr (mode_reg_wr),
    .sdm_clear   (sdm_clear),
    .test_hv     (test_hv),
    .smr_q       (smr_word)
  );

  smr_readback #(.DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .hit       (dec.hit),
    .pick      (dec.pick),
    .irq_en_fb (irq_en_fb),
    .irq_fb    (irq_fb),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  smr_pin #(.DIAG_W(DIAG_W)) u_pin (
    .clk            (clk),
    .rst            (rst),
    .emu            (smr_word[POS_EMU]),
    .limp           (smr_word[POS_LIMP]),
    .busfail_diag   (busfail_diag),
    .en_normal      (en_normal),
    .failsafe_entry (failsafe_entry),
    .en_pin         (en_pin),
    .cfg_limp       (cfg_limp)
  );

  always_comb suppress = smr_word[POS_DEV];

  p_ro_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && frame_word[ADDR_HI:ADDR_LO] == SEL_ADDR &&
     frame_word[POS_RO] && !sdm_clear) |=> $stable(smr_word))
    else $error("R4: read-only frame changed register");

  p_other_addr_r1: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && frame_word[ADDR_HI:ADDR_LO] != SEL_ADDR && !sdm_clear &&
     !test_hv) |=> $stable(smr_word))
    else $error("R1: unselected frame changed register");
endmodule

// File: tb/smr_once_reg_test.sv
`timescale 1ns/1ps
module smr_once_reg_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_valid = 1'b0;
  logic [15:0] frame_word = '0;
  logic        in_startup = 1'b1;
  logic        mode_reg_wr = 1'b0;
  logic        sdm_clear = 1'b0;
  logic        test_hv = 1'b0;
  logic [15:0] irq_en_fb = 16'hA5C3;
  logic [15:0] irq_fb = 16'h3C5A;
  logic [3:0]  busfail_diag = '0;
  logic        en_normal = 1'b0;
  logic        failsafe_entry = 1'b0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [15:0] smr_word;
  logic        suppress;
  logic        en_pin;
  logic        cfg_limp;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  smr_once_reg uut (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_word(frame_word),
    .in_startup(in_startup), .mode_reg_wr(mode_reg_wr), .sdm_clear(sdm_clear),
    .test_hv(test_hv), .irq_en_fb(irq_en_fb), .irq_fb(irq_fb),
    .busfail_diag(busfail_diag), .en_normal(en_normal),
    .failsafe_entry(failsafe_entry), .rd_valid(rd_valid), .rd_data(rd_data),
    .smr_word(smr_word), .suppress(suppress), .en_pin(en_pin),
    .cfg_limp(cfg_limp)
  );

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic tpin);
    @(negedge clk);
    rst = 1'b1; test_hv = tpin;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_hv = 1'b0;
  endtask

  task automatic send(input logic [15:0] w, input logic mw, input logic clr);
    @(negedge clk);
    frame_valid = 1'b1; frame_word = w; mode_reg_wr = mw; sdm_clear = clr;
    @(negedge clk);
    frame_valid = 1'b0; mode_reg_wr = 1'b0; sdm_clear = 1'b0;
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 smr_word", 32'(smr_word), 32'h0);
    check("R12 rd_valid", 32'(rd_valid), 32'h0);
    check("R12 rd_data", 32'(rd_data), 32'h0);
    check("R12 en_pin", 32'(en_pin), 32'h0);
    check("R12 cfg_limp", 32'(cfg_limp), 32'h0);
    check("R12 suppress", 32'(suppress), 32'h0);
    do_reset(1'b0);
    check("R6 no test pin", 32'(smr_word), 32'h0);
  endtask

  task automatic t_address;
    send(16'h8380, 1'b0, 1'b0);
    check("R1 other address rd_valid", 32'(rd_valid), 32'h0);
    check("R1 other address store", 32'(smr_word), 32'h0);
  endtask

  task automatic t_readonly;
    send(16'h5380, 1'b0, 1'b0);
    check("R4 ro rd_valid", 32'(rd_valid), 32'h1);
    check("R5 pick0 data", 32'(rd_data), 32'hA5C3);
    check("R4 ro store", 32'(smr_word), 32'h0);
    send(16'h7380, 1'b0, 1'b0);
    check("R5 pick1 data", 32'(rd_data), 32'h3C5A);
    @(negedge clk);
    check("R5 single pulse", 32'(rd_valid), 32'h0);
  endtask

  task automatic t_write_once;
    in_startup = 1'b0;
    send(16'h4380, 1'b0, 1'b0);
    check("R3 outside startup", 32'(smr_word), 32'h0);
    in_startup = 1'b1;
    send(16'h4DFF, 1'b0, 1'b0);
    check("R11 stored bits", 32'(smr_word), 32'h0180);
    check("R5 write returns data", 32'(rd_data), 32'hA5C3);
    check("R10 suppress low", 32'(suppress), 32'h0);
    busfail_diag = 4'h0;
    repeat (2) @(negedge clk);
    check("R8 emu clean", 32'(en_pin), 32'h1);
    busfail_diag = 4'h3;
    @(negedge clk);
    check("R8 emu fault", 32'(en_pin), 32'h0);
    busfail_diag = 4'h0;
    send(16'h4200, 1'b0, 1'b0);
    check("R2 second write ignored", 32'(smr_word), 32'h0180);
    check("R9 held before entry", 32'(cfg_limp), 32'h0);
    @(negedge clk);
    failsafe_entry = 1'b1;
    @(negedge clk);
    failsafe_entry = 1'b0;
    check("R9 limp set on entry", 32'(cfg_limp), 32'h1);
  endtask

  task automatic t_mode_lock;
    do_reset(1'b0);
    @(negedge clk);
    mode_reg_wr = 1'b1;
    @(negedge clk);
    mode_reg_wr = 1'b0;
    send(16'h4380, 1'b0, 1'b0);
    check("R3 mode write locks", 32'(smr_word), 32'h0);
    do_reset(1'b0);
    send(16'h4380, 1'b1, 1'b0);
    check("R3 same cycle reject", 32'(smr_word), 32'h0);
    en_normal = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 follows enable", 32'(en_pin), 32'h1);
    en_normal = 1'b0;
    @(negedge clk);
    check("R8 follows enable low", 32'(en_pin), 32'h0);
  endtask

  task automatic t_limp_clear;
    do_reset(1'b0);
    send(16'h4100, 1'b0, 1'b0);
    @(negedge clk);
    failsafe_entry = 1'b1;
    @(negedge clk);
    failsafe_entry = 1'b0;
    check("R9 limp clear on entry", 32'(cfg_limp), 32'h0);
  endtask

  task automatic t_test_pin;
    do_reset(1'b1);
    check("R6 test pin sets flag", 32'(smr_word), 32'h0200);
    check("R10 suppress high", 32'(suppress), 32'h1);
    @(negedge clk);
    mode_reg_wr = 1'b1;
    @(negedge clk);
    mode_reg_wr = 1'b0;
    check("R7 flag kept when locked", 32'(smr_word), 32'h0200);
    @(negedge clk);
    sdm_clear = 1'b1;
    @(negedge clk);
    sdm_clear = 1'b0;
    check("R7 clear while locked", 32'(smr_word), 32'h0);
    check("R10 suppress released", 32'(suppress), 32'h0);
    do_reset(1'b0);
    test_hv = 1'b1;
    repeat (2) @(negedge clk);
    test_hv = 1'b0;
    check("R6 late test pin ignored", 32'(smr_word), 32'h0);
    send(16'h4200, 1'b0, 1'b1);
    check("R7 clear beats write", 32'(smr_word), 32'h0);
    send(16'h4200, 1'b0, 1'b0);
    check("R2 lock after write", 32'(smr_word), 32'h0);
  endtask

  initial begin
    t_reset_state();
    t_address();
    t_readonly();
    t_write_once();
    t_mode_lock();
    t_limp_clear();
    t_test_pin();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule